// File: doc/BRIEF.md
# Link Control Register with Cycle Timer

This block holds the control flags of a serial-bus link layer in one 32-bit memory-mapped register and drives the isochronous cycle timer from them. Software never writes the register directly. A write to the set address ORs ones into the register, and a write to the clear address removes them. Two flags gate the receiver's acceptance of PHY packets and of self-ID packets. Three flags drive the timer: the rollover source, the counter enable and the cycle-master role.

The timer keeps a tick offset and a cycle count, packed as {count, offset} on `cyc_time`. In internal mode the offset wraps after a fixed number of link-clock ticks. In external mode a synchronized rising edge on `cyc_ext_in` forces the wrap. When the node is cycle master and the root-status input is high, every rollover raises a one-cycle cycle-start request. When the node is not master, a received cycle-start time overwrites the timer, so the timer follows the bus master. A pending cycle-too-long event clears the cycle-master flag and keeps it cleared.

Top module: `lct_link_ctrl`

## Requirements
- R1: A write to SET_ADDR (default E0h) sets every writable bit that is 1 in the write data. A write to CLR_ADDR (default E4h) clears every writable bit that is 1. Bits that are 0 in the write data keep their value.
- R2: The writable bits are 22 (rollover source), 21 (cycle master), 20 (timer run), 10 (PHY packet accept) and 9 (self-ID accept). All other bits always read 0. A read at either address returns the register, and a read at any other address returns 0.
- R3: With bit 20 set and bit 22 clear, the offset (cyc_time[11:0]) counts 0 to PERIOD-1 and then wraps to 0. Each wrap increments the count (cyc_time[24:12]), and the count wraps to 0 after CYCLE_WRAP-1. Bits 31:25 read 0.
- R4: With bit 20 clear, the offset and the count hold their value.
- R5: `cyc_start_req` is high for one cycle, in the cycle after a rollover, only when bit 21 was set and `root_in` was high. At that point the offset reads 0.
- R6: While `too_long_in` is high, bit 21 is cleared at the next clock and a set write to bit 21 has no effect. Other bits in the same write still apply.
- R7: With bits 20 and 22 set, the offset counts freely with no wrap at PERIOD. The third clock after `cyc_ext_in` rises sets the offset to 0 and increments the count. A held-high input gives only one rollover, and a rise while bit 20 is clear has no effect.
- R8: `phy_pkt_en` equals bit 10 AND `rx_ctx_en_in`. `selfid_en` equals bit 9, regardless of bit 10.
- R9: While bit 21 is clear, `cs_load` loads the offset from cs_time[11:0] and the count from cs_time[24:12]. While bit 21 is set, `cs_load` has no effect.
- R10: After reset the register reads 0, `cyc_time` is 0 and `cyc_start_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data (ones select bits) |
| reg_rdata | output | 32 | Read data |
| cyc_ext_in | input | 1 | Asynchronous external cycle strobe |
| root_in | input | 1 | Node is bus root |
| too_long_in | input | 1 | Cycle-too-long event pending |
| rx_ctx_en_in | input | 1 | Receive context enabled |
| cs_load | input | 1 | Received cycle-start time valid |
| cs_time | input | 32 | Received cycle-start time {count, offset} |
| cyc_time | output | 32 | Current {count, offset} |
| cyc_start_req | output | 1 | One-cycle cycle-start request |
| phy_pkt_en | output | 1 | Accept PHY packets |
| selfid_en | output | 1 | Accept self-ID packets |

## Verification
The internal mode is swept over a shrunken configuration (PERIOD 12, CYCLE_WRAP 5) through more than one full count wrap, with the expected value at every tick computed as quotient and remainder of the tick number. This separates an off-by-one at the offset wrap from an error at the count wrap. The same sweep runs with root high and again with root low, so a request that ignores root is caught. External mode is tried with a single rise, with a held-high input and with a rise while frozen, which separates edge detection from level sensing and from gating by the run bit. Register traffic uses single-bit writes, all-ones writes and writes during a too-long event, which separates the set/clear masking from the interlock.

// File: rtl/lct_pkg.sv
package lct_pkg;
  localparam int unsigned B_SRC    = 22;
  localparam int unsigned B_MASTER = 21;
  localparam int unsigned B_RUN    = 20;
  localparam int unsigned B_PHY    = 10;
  localparam int unsigned B_SELF   = 9;

  localparam logic [31:0] WRITABLE = (32'h1 << B_SRC) | (32'h1 << B_MASTER) |
                                     (32'h1 << B_RUN) | (32'h1 << B_PHY) |
                                     (32'h1 << B_SELF);

  // Set/clear merge of write data into the current register value.
  function automatic logic [31:0] apply_write(input logic [31:0] cur,
                                              input logic [31:0] wd,
                                              input logic        is_set);
    logic [31:0] sel;
    sel = wd & WRITABLE;
    return is_set ? (cur | sel) : (cur & ~sel);
  endfunction

  // True when v is the last value before a modulo-limit wrap.
  function automatic logic at_last(input logic [31:0] v, input logic [31:0] limit);
    return (v + 32'd1) >= limit;
  endfunction

  // Modulo-limit increment.
  function automatic logic [31:0] mod_inc(input logic [31:0] v, input logic [31:0] limit);
    return at_last(v, limit) ? 32'd0 : v + 32'd1;
  endfunction
endpackage

// File: rtl/lct_ctrl_reg.sv
module lct_ctrl_reg
  import lct_pkg::*;
#(
  parameter logic [7:0] SET_ADDR = 8'hE0,
  parameter logic [7:0] CLR_ADDR = 8'hE4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  input  logic        too_long,
  output logic [31:0] ctrl_q,
  output logic        addr_hit
);
  logic        set_hit;
  logic        clr_hit;
  logic [31:0] wd_eff;
  logic [31:0] ctrl_d;

  assign set_hit  = (addr == SET_ADDR);
  assign clr_hit  = (addr == CLR_ADDR);
  assign addr_hit = set_hit | clr_hit;

  always_comb begin
    wd_eff = wdata;
    if (too_long) wd_eff[B_MASTER] = 1'b0;
    ctrl_d = ctrl_q;
    if (wr_en && set_hit)      ctrl_d = apply_write(ctrl_q, wd_eff, 1'b1);
    else if (wr_en && clr_hit) ctrl_d = apply_write(ctrl_q, wdata, 1'b0);
    if (too_long) ctrl_d[B_MASTER] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/lct_edge_sync.sv
module lct_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise
);
  logic [STAGES-1:0] s_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) s_q[0] <= 1'b0;
    else        s_q[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) s_q[i] <= 1'b0;
      else        s_q[i] <= s_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= s_q[STAGES-1];
  end

  assign rise = s_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/lct_cycle_timer.sv
module lct_cycle_timer
  import lct_pkg::*;
#(
  parameter int unsigned PERIOD     = 3072,
  parameter int unsigned CYCLE_WRAP = 8000,
  parameter int unsigned OFF_W      = 12,
  parameter int unsigned CNT_W      = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ext_mode,
  input  logic             ext_rise,
  input  logic             load,
  input  logic [OFF_W-1:0] load_off,
  input  logic [CNT_W-1:0] load_cnt,
  output logic [OFF_W-1:0] offset_q,
  output logic [CNT_W-1:0] count_q,
  output logic             rollover
);
  always_comb begin
    rollover = 1'b0;
    if (run && !load)
      rollover = ext_mode ? ext_rise : at_last(32'(offset_q), 32'(PERIOD));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offset_q <= '0;
      count_q  <= '0;
    end else if (load) begin
      offset_q <= load_off;
      count_q  <= load_cnt;
    end else if (run) begin
      if (rollover) begin
        offset_q <= '0;
        count_q  <= CNT_W'(mod_inc(32'(count_q), 32'(CYCLE_WRAP)));
      end else begin
        offset_q <= offset_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lct_link_ctrl.sv
module lct_link_ctrl
  import lct_pkg::*;
#(
  parameter logic [7:0]  SET_ADDR    = 8'hE0,
  parameter logic [7:0]  CLR_ADDR    = 8'hE4,
  parameter int unsigned PERIOD      = 3072,
  parameter int unsigned CYCLE_WRAP  = 8000,
  parameter int unsigned OFF_W       = 12,
  parameter int unsigned CNT_W       = 13,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        cyc_ext_in,
  input  logic        root_in,
  input  logic        too_long_in,
  input  logic        rx_ctx_en_in,
  input  logic        cs_load,
  input  logic [31:0] cs_time,
  output logic [31:0] cyc_time,
  output logic        cyc_start_req,
  output logic        phy_pkt_en,
  output logic        selfid_en
);
  localparam int unsigned TIME_W = OFF_W + CNT_W;
  localparam int unsigned PAD_W  = 32 - TIME_W;

  logic [31:0]      ctrl_q;
  logic             addr_hit;
  logic             ext_rise;
  logic             load_taken;
  logic             rollover;
  logic [OFF_W-1:0] offset_q;
  logic [CNT_W-1:0] count_q;
  logic             unused_cs_hi;

  lct_ctrl_reg #(.SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .too_long (too_long_in),
    .ctrl_q   (ctrl_q),
    .addr_hit (addr_hit)
  );

  lct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cyc_ext_in),
    .rise  (ext_rise)
  );

  assign load_taken = cs_load & ~ctrl_q[B_MASTER];

  lct_cycle_timer #(
    .PERIOD(PERIOD), .CYCLE_WRAP(CYCLE_WRAP), .OFF_W(OFF_W), .CNT_W(CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl_q[B_RUN]),
    .ext_mode (ctrl_q[B_SRC]),
    .ext_rise (ext_rise),
    .load     (load_taken),
    .load_off (cs_time[OFF_W-1:0]),
    .load_cnt (cs_time[TIME_W-1:OFF_W]),
    .offset_q (offset_q),
    .count_q  (count_q),
    .rollover (rollover)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cyc_start_req <= 1'b0;
    else        cyc_start_req <= rollover & ctrl_q[B_MASTER] & root_in;
  end

  assign unused_cs_hi = ^cs_time[31:TIME_W];
  assign reg_rdata    = addr_hit ? ctrl_q : 32'h0;
  assign cyc_time     = {{PAD_W{1'b0}}, count_q, offset_q};
  assign phy_pkt_en   = ctrl_q[B_PHY] & rx_ctx_en_in;
  assign selfid_en    = ctrl_q[B_SELF];
endmodule

// File: rtl/lct_checker.sv
module lct_checker
  import lct_pkg::*;
#(
  parameter int unsigned OFF_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      ctrl_q,
  input logic             too_long_in,
  input logic             load_taken,
  input logic [OFF_W-1:0] offset_q,
  input logic             cyc_start_req,
  input logic             root_in,
  input logic             phy_pkt_en,
  input logic             rx_ctx_en_in
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~WRITABLE) == 32'h0);

  assert_master_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    too_long_in |=> !ctrl_q[B_MASTER]);

  assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[B_RUN] && !load_taken) |=> $stable(offset_q));

  assert_start_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start_req |-> ($past(root_in) && $past(ctrl_q[B_MASTER])));

  assert_start_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start_req |-> (offset_q == '0));

  assert_phy_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    phy_pkt_en |-> rx_ctx_en_in);
endmodule

bind lct_link_ctrl lct_checker #(.OFF_W(OFF_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ctrl_q        (ctrl_q),
  .too_long_in   (too_long_in),
  .load_taken    (load_taken),
  .offset_q      (offset_q),
  .cyc_start_req (cyc_start_req),
  .root_in       (root_in),
  .phy_pkt_en    (phy_pkt_en),
  .rx_ctx_en_in  (rx_ctx_en_in)
);

// File: tb/lct_link_ctrl_test.sv
module lct_link_ctrl_test;
  localparam int P = 12;
  localparam int W = 5;
  localparam logic [7:0] SA = 8'hE0;
  localparam logic [7:0] CA = 8'hE4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = SA;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cyc_ext_in = 1'b0;
  logic        root_in = 1'b0;
  logic        too_long_in = 1'b0;
  logic        rx_ctx_en_in = 1'b0;
  logic        cs_load = 1'b0;
  logic [31:0] cs_time = '0;
  logic [31:0] cyc_time;
  logic        cyc_start_req;
  logic        phy_pkt_en;
  logic        selfid_en;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lct_link_ctrl #(.PERIOD(P), .CYCLE_WRAP(W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_ext_in(cyc_ext_in),
    .root_in(root_in), .too_long_in(too_long_in), .rx_ctx_en_in(rx_ctx_en_in),
    .cs_load(cs_load), .cs_time(cs_time), .cyc_time(cyc_time),
    .cyc_start_req(cyc_start_req), .phy_pkt_en(phy_pkt_en), .selfid_en(selfid_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] tick_time(input int n);
    return (32'((n / P) % W) << 12) | 32'(n % P);
  endfunction

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = SA;
  endtask

  task automatic load_time(input logic [31:0] t);
    @(negedge clk);
    cs_load = 1'b1; cs_time = t;
    @(negedge clk);
    cs_load = 1'b0;
  endtask

  task automatic read_at(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
    reg_addr = SA;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] snap;
    logic [31:0] c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    read_at(SA, v);
    check("R10 reg", v, 32'h0);
    check("R10 time", cyc_time, 32'h0);
    check("R10 start", 32'(cyc_start_req), 32'h0);

    // R1/R2 set all, read at both addresses, reserved bits zero
    reg_write(SA, 32'hFFFF_FFFF);
    read_at(SA, v); check("R2 set addr read", v, 32'h0070_0600);
    read_at(CA, v); check("R2 clr addr read", v, 32'h0070_0600);
    read_at(8'h10, v); check("R2 other addr", v, 32'h0);
    reg_write(CA, 32'hFFFF_FFFF);
    read_at(SA, v); check("R1 clear all", v, 32'h0);

    // R1 zero bits leave register unchanged
    reg_write(SA, 32'h0000_0200);
    reg_write(SA, 32'h0000_0400);
    read_at(SA, v); check("R1 accumulate set", v, 32'h0000_0600);
    reg_write(CA, 32'h0000_0200);
    read_at(CA, v); check("R1 partial clear", v, 32'h0000_0400);

    // R8 accept outputs
    rx_ctx_en_in = 1'b0; #1;
    check("R8 phy gated off", 32'(phy_pkt_en), 32'h0);
    rx_ctx_en_in = 1'b1; #1;
    check("R8 phy on", 32'(phy_pkt_en), 32'h1);
    check("R8 selfid off", 32'(selfid_en), 32'h0);
    reg_write(SA, 32'h0000_0200);
    reg_write(CA, 32'h0000_0400);
    check("R8 selfid independent of bit 10", 32'(selfid_en), 32'h1);
    check("R8 phy cleared", 32'(phy_pkt_en), 32'h0);
    reg_write(CA, 32'h0000_0200);

    // R9 load while not master
    load_time(32'h0000_3007);
    check("R9 load", cyc_time, 32'h0000_3007);
    load_time(32'h0);
    check("R9 load zero", cyc_time, 32'h0);

    // R3/R5 sweep, master and root
    root_in = 1'b1;
    reg_write(SA, 32'h0020_0000);
    load_time(32'h0000_2005);
    check("R9 load ignored when master", cyc_time, 32'h0);
    reg_write(SA, 32'h0010_0000);
    check("R3 start tick", cyc_time, 32'h0);
    for (int n = 1; n <= P * W + 4; n++) begin
      @(negedge clk);
      check("R3 sweep time", cyc_time, tick_time(n));
      check("R5 sweep start", 32'(cyc_start_req), 32'((n % P) == 0));
    end

    // R4 freeze
    reg_write(CA, 32'h0010_0000);
    snap = cyc_time;
    repeat (P + 2) begin
      @(negedge clk);
      check("R4 frozen", cyc_time, snap);
      check("R4 no start while frozen", 32'(cyc_start_req), 32'h0);
    end

    // R5 root low gives no request
    root_in = 1'b0;
    reg_write(SA, 32'h0010_0000);
    repeat (2 * P + 2) begin
      @(negedge clk);
      check("R5 no start without root", 32'(cyc_start_req), 32'h0);
    end
    reg_write(CA, 32'h0010_0000);

    // R6 too-long interlock
    @(negedge clk);
    too_long_in = 1'b1;
    @(negedge clk);
    read_at(SA, v); check("R6 master cleared", v & 32'h0020_0000, 32'h0);
    reg_write(SA, 32'h0020_0200);
    read_at(SA, v); check("R6 set ignored", v & 32'h0020_0000, 32'h0);
    check("R6 other bit applied", v & 32'h0000_0200, 32'h0000_0200);
    too_long_in = 1'b0;
    reg_write(SA, 32'h0020_0000);
    read_at(SA, v); check("R6 set after release", v & 32'h0020_0000, 32'h0020_0000);

    // R7 external source
    reg_write(CA, 32'h0020_0200);
    load_time(32'h0);
    reg_write(SA, 32'h0050_0000);
    repeat (P + 3) @(negedge clk);
    check("R7 no internal wrap", cyc_time, 32'(P + 3));
    c0 = cyc_time >> 12;
    cyc_ext_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 rise rolls over", cyc_time, ((c0 + 1) % W) << 12);
    repeat (5) @(negedge clk);
    check("R7 held high once", cyc_time, (((c0 + 1) % W) << 12) | 32'd5);
    cyc_ext_in = 1'b0;
    repeat (4) @(negedge clk);
    reg_write(CA, 32'h0010_0000);
    snap = cyc_time;
    cyc_ext_in = 1'b1;
    repeat (5) @(negedge clk);
    check("R7 rise ignored when stopped", cyc_time, snap);
    cyc_ext_in = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule